// File: doc/BRIEF.md
# Accumulator ALU with Status Flags

This block executes one group of register-to-accumulator instructions of a small 8-bit processor: add, add with carry, subtract, subtract with borrow and bitwise AND. The caller presents an opcode byte together with the current accumulator, seven general registers and the incoming carry. It then pulses a strobe. The block captures the operands on that edge and steps through a fixed sequence of four T states. On the last state it writes back the new accumulator and a packed status byte.

The status byte follows rules that depend on the operation. For the arithmetic operations the parity/overflow flag reports signed overflow. For AND it reports even parity. AND forces the half-carry flag. The subtract flag records whether the last operation was a subtraction. Opcodes outside the group are flagged as illegal and do not touch the accumulator or the status byte.

Top module: `acc_alu`

## Requirements
- R1: The opcode is decoded as follows. Bits 7..6 must be `10`. Bits 5..3 select the operation: 000 add, 001 add with carry, 010 subtract, 011 subtract with borrow, 100 AND. Bits 2..0 select the source: values 0..6 pick `regs_in` entry n, taken from bits n*8+7..n*8, and 111 picks the accumulator itself.
- R2: A strobe is accepted on a rising edge where `busy` is low, and that edge counts as T state 1. `busy` is high for the next three cycles. On the fourth rising edge, counting the accepting edge, `acc_out` and `flags_out` update and `done` goes high for exactly one cycle while `busy` is low. At no other time do `acc_out` and `flags_out` change.
- R3: Add computes A + r and add with carry computes A + r + `carry_in`, modulo 256. C is set on a carry out of bit 7.
- R4: For the two add operations, H is set on a carry out of bit 3 and N is cleared.
- R5: Subtract computes A − r and subtract with borrow computes A − r − `carry_in`, modulo 256. N is set, C is set on a borrow out of the byte, and H is set on a borrow out of bit 4 (a low-nibble borrow).
- R6: For the four arithmetic operations, P/V is set exactly when the signed 8-bit result overflows.
- R7: For AND, H is forced to 1, C to 0 and N to 0, and P/V is set when the result has an even number of one bits.
- R8: For all five operations, S equals result bit 7 and Z is set when the result is zero.
- R9: `flags_out` packs S, Z, H, P/V, N and C at bit positions 7, 6, 4, 2, 1 and 0. Bits 5 and 3 always read 0.
- R10: An opcode outside the group completes in the same four T states with `done` and `illegal` high together for one cycle. `acc_out` and `flags_out` keep their previous values.
- R11: A strobe that arrives while an instruction is in progress is ignored, and the result of the running instruction is unaffected.
- R12: After reset `acc_out`, `flags_out`, `busy`, `done` and `illegal` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_strobe | input | 1 | Start request for the presented opcode |
| opcode | input | 8 | Instruction byte |
| acc_in | input | 8 | Current accumulator value |
| regs_in | input | 56 | Seven general registers, entry n in bits n*8+7..n*8 |
| carry_in | input | 1 | Current carry flag |
| acc_out | output | 8 | Accumulator written back at completion |
| flags_out | output | 8 | Packed status byte written back at completion |
| busy | output | 1 | Instruction in T states 2 to 4 |
| done | output | 1 | One-cycle completion pulse |
| illegal | output | 1 | Completion of an opcode outside the group |

## Verification
The bench builds the block with its defaults: an 8-bit datapath, an eight-code source field and a four-state sequence. At these values all 256 opcode bytes can be swept, so every illegal group code and every source code, including the accumulator self-select, is reached. Directed operands push the half-carry, the byte carry, signed overflow in both directions and both parity outcomes. A strobe held across a running instruction exercises the rule that requests are ignored while busy.

// File: rtl/acc_alu_pkg.sv
`timescale 1ns/1ps
package acc_alu_pkg;

    typedef enum logic [2:0] {
        OP_ADD = 3'd0,
        OP_ADC = 3'd1,
        OP_SUB = 3'd2,
        OP_SBC = 3'd3,
        OP_AND = 3'd4
    } alu_op_e;

    // bit positions inside the packed status byte
    localparam int unsigned FB_S  = 7;
    localparam int unsigned FB_Z  = 6;
    localparam int unsigned FB_H  = 4;
    localparam int unsigned FB_PV = 2;
    localparam int unsigned FB_N  = 1;
    localparam int unsigned FB_C  = 0;

    typedef struct packed {
        logic s;
        logic z;
        logic h;
        logic pv;
        logic n;
        logic c;
    } alu_flags_t;

    function automatic logic [7:0] pack_flags(alu_flags_t f);
        logic [7:0] b;
        b        = 8'h00;
        b[FB_S]  = f.s;
        b[FB_Z]  = f.z;
        b[FB_H]  = f.h;
        b[FB_PV] = f.pv;
        b[FB_N]  = f.n;
        b[FB_C]  = f.c;
        return b;
    endfunction

endpackage

// File: rtl/acc_alu_decode.sv
`timescale 1ns/1ps
module acc_alu_decode
    import acc_alu_pkg::*;
#(
    parameter int SRC_W = 3
) (
    input  logic [7:0]       opcode,
    output alu_op_e          op,
    output logic [SRC_W-1:0] src,
    output logic             src_is_acc,
    output logic             bad
);
    localparam logic [1:0] GROUP_CODE = 2'b10;

    always_comb begin
        src        = opcode[SRC_W-1:0];
        src_is_acc = &opcode[SRC_W-1:0];
        op         = OP_ADD;
        bad        = 1'b1;
        if (opcode[7:6] == GROUP_CODE) begin
            case (opcode[5:3])
                3'd0: begin op = OP_ADD; bad = 1'b0; end
                3'd1: begin op = OP_ADC; bad = 1'b0; end
                3'd2: begin op = OP_SUB; bad = 1'b0; end
                3'd3: begin op = OP_SBC; bad = 1'b0; end
                3'd4: begin op = OP_AND; bad = 1'b0; end
                default: begin op = OP_ADD; bad = 1'b1; end
            endcase
        end
    end
endmodule

// File: rtl/acc_alu_exec.sv
`timescale 1ns/1ps
module acc_alu_exec
    import acc_alu_pkg::*;
#(
    parameter int DW = 8
) (
    input  alu_op_e       op,
    input  logic [DW-1:0] a,
    input  logic [DW-1:0] b,
    input  logic          cin,
    output logic [DW-1:0] res,
    output alu_flags_t    fl
);
    localparam int HB = 4;   // half-carry boundary

    logic          is_sub;
    logic          use_c;
    logic          carry0;
    logic [DW-1:0] b_eff;
    logic [DW:0]   full;
    logic [HB:0]   low;

    always_comb begin
        is_sub = (op == OP_SUB) || (op == OP_SBC);
        use_c  = ((op == OP_ADC) || (op == OP_SBC)) && cin;
        // subtraction as a + ~b + 1, minus the borrow-in
        b_eff  = is_sub ? ~b : b;
        carry0 = is_sub ? ~use_c : use_c;
        full   = {1'b0, a} + {1'b0, b_eff} + {{DW{1'b0}}, carry0};
        low    = {1'b0, a[HB-1:0]} + {1'b0, b_eff[HB-1:0]} + {{HB{1'b0}}, carry0};

        fl = '0;
        if (op == OP_AND) begin
            res   = a & b;
            fl.h  = 1'b1;
            fl.c  = 1'b0;
            fl.n  = 1'b0;
            fl.pv = ~^res;
        end else begin
            res   = full[DW-1:0];
            fl.c  = is_sub ? ~full[DW] : full[DW];
            fl.h  = is_sub ? ~low[HB]  : low[HB];
            fl.n  = is_sub;
            fl.pv = (a[DW-1] == b_eff[DW-1]) && (full[DW-1] != a[DW-1]);
        end
        fl.s = res[DW-1];
        fl.z = (res == '0);
    end
endmodule

// File: rtl/acc_alu_tstate.sv
`timescale 1ns/1ps
module acc_alu_tstate #(
    parameter int TSTATES = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy,
    output logic last
);
    localparam int CW = $clog2(TSTATES + 1);
    localparam logic [CW-1:0] FINAL_T = CW'(TSTATES - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } ts_st_t;

    ts_st_t st_d, st_q;

    assign busy = (st_q.cnt != '0);
    assign last = busy && (st_q.cnt == FINAL_T);

    always_comb begin
        st_d = st_q;
        if (!busy && start) begin
            st_d.cnt = CW'(1);
        end else if (last) begin
            st_d.cnt = '0;
        end else if (busy) begin
            st_d.cnt = st_q.cnt + CW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    AST_TSTATE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= FINAL_T);                                                   // R2
    AST_TSTATE_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !last) |=> (st_q.cnt == $past(st_q.cnt) + CW'(1)));           // R2
endmodule

// File: rtl/acc_alu.sv
`timescale 1ns/1ps
module acc_alu
    import acc_alu_pkg::*;
#(
    parameter int DW      = 8,
    parameter int NREG    = 8,
    parameter int TSTATES = 4
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   op_strobe,
    input  logic [7:0]             opcode,
    input  logic [DW-1:0]          acc_in,
    input  logic [(NREG-1)*DW-1:0] regs_in,
    input  logic                   carry_in,
    output logic [DW-1:0]          acc_out,
    output logic [7:0]             flags_out,
    output logic                   busy,
    output logic                   done,
    output logic                   illegal
);
    localparam int SRC_W = $clog2(NREG);
    localparam int NGPR  = NREG - 1;

    typedef struct packed {
        logic [DW-1:0] acc;
        logic [7:0]    flags;
        logic          done;
        logic          illegal;
        alu_op_e       op;
        logic          bad;
        logic [DW-1:0] opa;
        logic [DW-1:0] opb;
        logic          cin;
    } core_st_t;

    core_st_t st_d, st_q;

    alu_op_e          dec_op;
    logic [SRC_W-1:0] dec_src;
    logic             dec_src_acc;
    logic             dec_bad;
    logic [DW-1:0]    src_val;
    logic [DW-1:0]    ex_res;
    alu_flags_t       ex_fl;
    logic             ts_busy;
    logic             ts_last;
    logic             accept;

    acc_alu_decode #(.SRC_W(SRC_W)) u_decode (
        .opcode     (opcode),
        .op         (dec_op),
        .src        (dec_src),
        .src_is_acc (dec_src_acc),
        .bad        (dec_bad)
    );

    // source operand: general register or the accumulator itself
    always_comb begin
        src_val = acc_in;
        for (int i = 0; i < NGPR; i++) begin
            if (!dec_src_acc && (dec_src == SRC_W'(i))) begin
                src_val = regs_in[i*DW +: DW];
            end
        end
    end

    acc_alu_tstate #(.TSTATES(TSTATES)) u_tstate (
        .clk   (clk),
        .rst_n (rst_n),
        .start (op_strobe),
        .busy  (ts_busy),
        .last  (ts_last)
    );

    acc_alu_exec #(.DW(DW)) u_exec (
        .op  (st_q.op),
        .a   (st_q.opa),
        .b   (st_q.opb),
        .cin (st_q.cin),
        .res (ex_res),
        .fl  (ex_fl)
    );

    assign accept = op_strobe && !ts_busy;

    always_comb begin
        st_d         = st_q;
        st_d.done    = 1'b0;
        st_d.illegal = 1'b0;
        if (accept) begin
            st_d.op  = dec_op;
            st_d.bad = dec_bad;
            st_d.opa = acc_in;
            st_d.opb = src_val;
            st_d.cin = carry_in;
        end
        if (ts_last) begin
            st_d.done = 1'b1;
            if (st_q.bad) begin
                st_d.illegal = 1'b1;
            end else begin
                st_d.acc   = ex_res;
                st_d.flags = pack_flags(ex_fl);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q    <= '0;
            st_q.op <= OP_ADD;
        end else begin
            st_q <= st_d;
        end
    end

    assign acc_out   = st_q.acc;
    assign flags_out = st_q.flags;
    assign busy      = ts_busy;
    assign done      = st_q.done;
    assign illegal   = st_q.illegal;

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);                                                        // R2
    AST_DONE_AFTER_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ($past(busy) && !busy));                                       // R2
    AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> ($stable(acc_out) && $stable(flags_out)));                    // R2
    AST_ILLEGAL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |-> (done && $stable(acc_out) && $stable(flags_out)));          // R10
    AST_AND_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !illegal && st_q.op == OP_AND) |->
        (flags_out[FB_H] && !flags_out[FB_C] && !flags_out[FB_N]));             // R7
    AST_SUB_MARK: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !illegal) |->
        (flags_out[FB_N] == (st_q.op == OP_SUB || st_q.op == OP_SBC)));         // R5
    AST_SIGN_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !illegal) |->
        (flags_out[FB_Z] == (acc_out == '0) && flags_out[FB_S] == acc_out[DW-1])); // R8
endmodule

// File: tb/sim_acc_alu.sv
`timescale 1ns/1ps
module sim_acc_alu;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_strobe = 1'b0;
    logic [7:0]  opcode = 8'h00;
    logic [7:0]  acc_in = 8'h00;
    logic [55:0] regs_in;
    logic        carry_in = 1'b0;
    logic [7:0]  acc_out;
    logic [7:0]  flags_out;
    logic        busy;
    logic        done;
    logic        illegal;

    logic [7:0]  regs [7];

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    always_comb begin
        for (int i = 0; i < 7; i++) regs_in[i*8 +: 8] = regs[i];
    end

    acc_alu u0 (
        .clk(clk), .rst_n(rst_n), .op_strobe(op_strobe), .opcode(opcode),
        .acc_in(acc_in), .regs_in(regs_in), .carry_in(carry_in),
        .acc_out(acc_out), .flags_out(flags_out), .busy(busy),
        .done(done), .illegal(illegal)
    );

    // behavioural result: {illegal, acc, flags}
    function automatic logic [16:0] ref_exec(int opc, int a, int b, int cin);
        int op, ci, res, full, c, h, v, n, s, z, sa, sb, sum, ones, fl;
        op = (opc >> 3) & 7;
        if (((opc >> 6) & 3) != 2 || op > 4) return {1'b1, 16'h0000};
        ci = (op == 1 || op == 3) ? cin : 0;
        sa = (a > 127) ? a - 256 : a;
        sb = (b > 127) ? b - 256 : b;
        if (op <= 1) begin
            full = a + b + ci;
            res = full & 255; c = (full > 255);
            h = (((a & 15) + (b & 15) + ci) > 15);
            sum = sa + sb + ci; v = (sum > 127 || sum < -128); n = 0;
        end else if (op <= 3) begin
            full = a - b - ci;
            res = full & 255; c = (full < 0);
            h = (((a & 15) - (b & 15) - ci) < 0);
            sum = sa - sb - ci; v = (sum > 127 || sum < -128); n = 1;
        end else begin
            res = a & b; ones = 0;
            for (int k = 0; k < 8; k++) ones += (res >> k) & 1;
            v = (ones % 2 == 0); h = 1; c = 0; n = 0;
        end
        s = (res >= 128); z = (res == 0);
        fl = s*128 + z*64 + h*16 + v*4 + n*2 + c;
        return {1'b0, res[7:0], fl[7:0]};
    endfunction

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // cycle-by-cycle reference model
    logic        m_busy, m_done, m_ill;
    int          m_cnt;
    logic [7:0]  m_acc, m_flags;
    logic [16:0] m_pend;
    logic [16:0] m_tmp;
    logic [7:0]  m_b;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_busy <= 0; m_cnt <= 0; m_done <= 0; m_ill <= 0;
            m_acc <= 0; m_flags <= 0; m_pend <= 0;
        end else begin
            m_done <= 0; m_ill <= 0;
            if (!m_busy) begin
                if (op_strobe) begin
                    m_b = ((opcode & 8'h07) == 8'h07) ? acc_in : regs[opcode[2:0]];
                    m_tmp = ref_exec(opcode, acc_in, m_b, carry_in);
                    m_pend <= m_tmp; m_busy <= 1; m_cnt <= 1;
                end
            end else if (m_cnt == 3) begin
                m_busy <= 0; m_cnt <= 0; m_done <= 1;
                if (m_pend[16]) m_ill <= 1;
                else begin m_acc <= m_pend[15:8]; m_flags <= m_pend[7:0]; end
            end else begin
                m_cnt <= m_cnt + 1;
            end
        end
    end

    always @(negedge clk) begin
        if (rst_n && !finished) begin
            chk(done == m_done, "R2 done timing", done, m_done);
            chk(busy == m_busy, "R2 busy timing", busy, m_busy);
            chk(illegal == m_ill, "R10 illegal flag", illegal, m_ill);
            chk(acc_out == m_acc, "R2 acc_out model", acc_out, m_acc);
            chk(flags_out == m_flags, "R2 flags_out model", flags_out, m_flags);
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc == 150000 && !finished) begin
            finished = 1;
            errors++;
            $display("FAIL R2 watchdog actual=hung expected=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    // starts just after a negedge, returns just after a negedge
    task automatic do_op(input int opc, input int a, input int b, input int ci, input string tag);
        logic [16:0] e;
        int pa, pf;
        bit seen;
        pa = acc_out; pf = flags_out;
        for (int i = 0; i < 7; i++) regs[i] = b[7:0];
        opcode = opc[7:0]; acc_in = a[7:0]; carry_in = ci[0]; op_strobe = 1'b1;
        @(negedge clk); #1 op_strobe = 1'b0;
        seen = 0;
        for (int i = 0; i < 8 && !seen; i++) begin
            @(negedge clk);
            if (done) seen = 1;
        end
        e = ref_exec(opc, a, ((opc & 7) == 7) ? a : b, ci);
        chk(seen, {tag, " done seen"}, seen, 1);
        if (e[16]) begin
            chk(illegal == 1'b1, "R10 illegal raised", illegal, 1);
            chk(acc_out == pa[7:0], "R10 acc kept", acc_out, pa);
            chk(flags_out == pf[7:0], "R10 flags kept", flags_out, pf);
        end else begin
            chk(acc_out == e[15:8], {tag, " result"}, acc_out, e[15:8]);
            chk(flags_out == e[7:0], {tag, " flags"}, flags_out, e[7:0]);
            chk((flags_out & 8'h28) == 0, "R9 spare bits", flags_out & 8'h28, 0);
        end
        #1;
    endtask

    initial begin
        for (int i = 0; i < 7; i++) regs[i] = 8'h00;
        repeat (4) @(negedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        chk(acc_out == 0 && flags_out == 0, "R12 reset outputs", {acc_out, flags_out}, 0);
        chk(!busy && !done && !illegal, "R12 reset status", {busy, done, illegal}, 0);
        #1;

        do_op(8'h80, 8'h0F, 8'h01, 0, "R4 add half carry");
        chk(acc_out == 8'h10 && flags_out == 8'h10, "R4 add 0F+01", {acc_out, flags_out}, 16'h1010);
        do_op(8'h83, 8'h80, 8'h80, 0, "R6 add overflow");
        chk(flags_out == 8'h45, "R6 add 80+80 flags", flags_out, 8'h45);
        do_op(8'h8A, 8'hFF, 8'h00, 1, "R3 adc carry in");
        chk(acc_out == 8'h00 && flags_out[0], "R3 adc FF+00+1", {acc_out, flags_out}, 16'h0051);
        do_op(8'h88, 8'h7F, 8'h00, 1, "R3 adc positive overflow");
        do_op(8'h91, 8'h10, 8'h01, 0, "R5 sub half borrow");
        do_op(8'h9C, 8'h00, 8'h00, 1, "R5 sbc borrow in");
        chk(acc_out == 8'hFF && flags_out == 8'h93, "R5 sbc 00-00-1", {acc_out, flags_out}, 16'hFF93);
        do_op(8'h92, 8'h80, 8'h01, 0, "R6 sub overflow");
        chk(flags_out[2] == 1'b1, "R6 sub 80-01 overflow", flags_out[2], 1);
        do_op(8'h98, 8'h80, 8'h7F, 1, "R6 sbc overflow");
        do_op(8'hA5, 8'h0F, 8'h03, 0, "R7 and even parity");
        chk(acc_out == 8'h03 && flags_out == 8'h14, "R7 and 0F&03", {acc_out, flags_out}, 16'h0314);
        do_op(8'hA6, 8'h07, 8'hFF, 1, "R7 and odd parity");
        chk(flags_out == 8'h10, "R7 and 07&FF flags", flags_out, 8'h10);
        do_op(8'hA0, 8'hF0, 8'h0F, 0, "R8 and zero result");
        chk(flags_out[6] == 1'b1, "R8 zero flag", flags_out[6], 1);
        do_op(8'h87, 8'h21, 8'h55, 0, "R1 accumulator self source");
        chk(acc_out == 8'h42, "R1 self add 21+21", acc_out, 8'h42);
        do_op(8'h00, 8'h11, 8'h22, 0, "R10 group 00");
        do_op(8'hA8, 8'h11, 8'h22, 0, "R10 op 101");
        do_op(8'hFF, 8'h11, 8'h22, 0, "R10 group 11");

        // R11: strobe held while busy with changed inputs
        for (int i = 0; i < 7; i++) regs[i] = 8'h01;
        opcode = 8'h80; acc_in = 8'h01; carry_in = 0; op_strobe = 1'b1;
        @(negedge clk); #1 opcode = 8'h90; acc_in = 8'h50;
        @(negedge clk); @(negedge clk); #1 op_strobe = 1'b0;
        @(negedge clk);
        chk(done && acc_out == 8'h02, "R11 busy strobe ignored", {done, acc_out}, 16'h0102);
        @(negedge clk);
        chk(!busy && !done, "R11 no extra start", {busy, done}, 0);
        #1;

        // R1: sweep every opcode byte
        for (int k = 0; k < 256; k++)
            do_op(k, $urandom & 255, $urandom & 255, $urandom & 1, "R1 opcode sweep");
        // R3 R5 R6: random legal operations
        for (int k = 0; k < 400; k++)
            do_op(8'h80 | (($urandom % 5) << 3) | ($urandom & 7),
                  $urandom & 255, $urandom & 255, $urandom & 1, "R6 random legal");

        finished = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule